// File: doc/BRIEF.md
# Sequential Booth Multiplier

This block multiplies two 32-bit operands over a series of clock cycles, one multiplier bit per cycle. It uses a single adder/subtractor one bit wider than an operand. It also uses one product register that holds the running upper half, the not-yet-consumed multiplier bits in its lower half, and one guard bit to the right of bit 0. A mode input chooses between signed operation and unsigned operation. In signed mode each bit pair is recoded into add, subtract or skip. In unsigned mode the block does plain shift-and-add.

A client raises `start_i` for one cycle with the operands and the mode. The block then runs by itself. When the last step is done it pulses `done_o` for one cycle. At the same edge it places the upper and lower words of the double-width product on `hi_o` and `lo_o`, and those words stay there until the next product is done.

Top module: `booth_mul_seq`

## Requirements
- R1: While reset is high and after it is released, `hi_o` and `lo_o` read 0 and `done_o` reads 0 until the first product completes.
- R2: In signed mode (`signed_i`=1) the result `{hi_o,lo_o}` is the two's-complement product of `mcand_i` and `mplier_i`. Each step examines the pair (bit 0, guard bit): 10 subtracts the multiplicand from the upper half, 01 adds it, and 00 or 11 leaves the upper half unchanged. The register then shifts right by one with the sign replicated.
- R3: In unsigned mode (`signed_i`=0) the result is the unsigned product. Bit 0 alone decides whether the multiplicand is added, the carry of that 33-bit sum enters at the top, and the shift fills with that carry.
- R4: If `start_i` is sampled at rising edge k while the block is idle, `done_o` is high during exactly the one cycle after edge k+WIDTH and is low in every other cycle.
- R5: A `start_i` pulse sampled while a product is in progress is ignored. The running product, its completion time and the next results are unaffected.
- R6: `hi_o` and `lo_o` change only at the edge that raises `done_o`, and otherwise hold their last value, including all through the following computation.
- R7: Signed corner values produce exact results. The most negative value times itself gives 2^62, and the most negative value times -1 gives +2^31 in the low word with a zero high word.
- R8: In unsigned mode, all-ones times all-ones gives 0xFFFFFFFE_00000001, which exercises the carry into the top bit.
- R9: The mode and the operands are captured at the accepted start. Changing `signed_i`, `mcand_i` or `mplier_i` while busy has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | One-cycle request to begin a product |
| signed_i | input | 1 | 1 = signed recoded mode, 0 = unsigned shift-add mode |
| mcand_i | input | WIDTH | Multiplicand |
| mplier_i | input | WIDTH | Multiplier |
| hi_o | output | WIDTH | Upper word of the last completed product |
| lo_o | output | WIDTH | Lower word of the last completed product |
| done_o | output | 1 | One-cycle pulse when a new product is on the outputs |

## Verification
An accepted start at edge k makes the product and the done pulse due exactly WIDTH edges later. No output is due to change at any other edge. The bench runs a behavioural model that counts the same edges from the same sampled start. It compares `done_o`, `hi_o` and `lo_o` against that model in the middle of every clock cycle. A late or early pulse, a lingering pulse, or a word that moves outside its edge is therefore caught in the exact cycle where it happens. Starts issued mid-run and mode changes mid-run run against the same model, which drops or ignores them.

// File: rtl/booth_mul_pkg.sv
package booth_mul_pkg;
  typedef enum logic [1:0] {
    STEP_SKIP = 2'd0,
    STEP_ADD  = 2'd1,
    STEP_SUB  = 2'd2
  } step_op_e;
endpackage

// File: rtl/booth_recode.sv
module booth_recode
  import booth_mul_pkg::*;
(
  input  logic     mode_signed,
  input  logic     cur_bit,
  input  logic     right_bit,
  output step_op_e op
);
  always_comb begin
    op = STEP_SKIP;
    if (mode_signed) begin
      // pair (current, right): 10 -> subtract, 01 -> add
      unique case ({cur_bit, right_bit})
        2'b10:   op = STEP_SUB;
        2'b01:   op = STEP_ADD;
        default: op = STEP_SKIP;
      endcase
    end else if (cur_bit) begin
      op = STEP_ADD;
    end
  end
endmodule

// File: rtl/booth_addsub.sv
module booth_addsub
  import booth_mul_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             mode_signed,
  input  step_op_e         op,
  input  logic [WIDTH-1:0] upper,
  input  logic [WIDTH-1:0] mcand,
  output logic [WIDTH:0]   sum
);
  logic [WIDTH:0] upper_x;
  logic [WIDTH:0] mcand_x;

  // one extra bit so the sign (signed) or carry (unsigned) survives the shift
  assign upper_x = {mode_signed & upper[WIDTH-1], upper};
  assign mcand_x = {mode_signed & mcand[WIDTH-1], mcand};

  always_comb begin
    unique case (op)
      STEP_ADD: sum = upper_x + mcand_x;
      STEP_SUB: sum = upper_x - mcand_x;
      default:  sum = upper_x;
    endcase
  end
endmodule

// File: rtl/booth_seq_ctrl.sv
module booth_seq_ctrl #(
  parameter int WIDTH = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic load,
  output logic busy,
  output logic last,
  output logic done_o
);
  localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [CW-1:0] LAST_STEP = CW'(WIDTH - 1);

  logic [CW-1:0] step_cnt;

  assign load = start_i & ~busy;
  assign last = busy & (step_cnt == LAST_STEP);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      step_cnt <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o <= last;
      if (load) begin
        busy     <= 1'b1;
        step_cnt <= '0;
      end else if (busy) begin
        step_cnt <= step_cnt + 1'b1;
        if (last) busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/booth_mul_seq.sv
module booth_mul_seq
  import booth_mul_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             signed_i,
  input  logic [WIDTH-1:0] mcand_i,
  input  logic [WIDTH-1:0] mplier_i,
  output logic [WIDTH-1:0] hi_o,
  output logic [WIDTH-1:0] lo_o,
  output logic             done_o
);
  logic             load, busy, last;
  logic [WIDTH-1:0] acc_hi, acc_lo;
  logic             guard;
  logic [WIDTH-1:0] mcand_q;
  logic             mode_q;
  step_op_e         op;
  logic [WIDTH:0]   sum;
  logic [WIDTH-1:0] nxt_hi, nxt_lo;

  booth_seq_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk(clk), .rst(rst), .start_i(start_i),
    .load(load), .busy(busy), .last(last), .done_o(done_o)
  );

  booth_recode u_rec (
    .mode_signed(mode_q), .cur_bit(acc_lo[0]), .right_bit(guard), .op(op)
  );

  booth_addsub #(.WIDTH(WIDTH)) u_as (
    .mode_signed(mode_q), .op(op), .upper(acc_hi), .mcand(mcand_q), .sum(sum)
  );

  // shift of {sum, acc_lo, guard} right by one; top bit of sum fills in
  assign nxt_hi = sum[WIDTH:1];
  assign nxt_lo = {sum[0], acc_lo[WIDTH-1:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_hi  <= '0;
      acc_lo  <= '0;
      guard   <= 1'b0;
      mcand_q <= '0;
      mode_q  <= 1'b0;
      hi_o    <= '0;
      lo_o    <= '0;
    end else begin
      if (load) begin
        acc_hi  <= '0;
        acc_lo  <= mplier_i;
        guard   <= 1'b0;
        mcand_q <= mcand_i;
        mode_q  <= signed_i;
      end else if (busy) begin
        acc_hi <= nxt_hi;
        acc_lo <= nxt_lo;
        guard  <= acc_lo[0];
        if (last) begin
          hi_o <= nxt_hi;
          lo_o <= nxt_lo;
        end
      end
    end
  end
endmodule

// File: rtl/booth_mul_seq_chk.sv
module booth_mul_seq_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             start_i,
  input logic             busy,
  input logic             done_o,
  input logic [WIDTH-1:0] hi_o,
  input logic [WIDTH-1:0] lo_o
);
  localparam int KW = $clog2(WIDTH + 1) + 1;
  logic [KW-1:0] run_cyc;

  always_ff @(posedge clk) begin
    if (rst) run_cyc <= '0;
    else if (start_i && !busy) run_cyc <= '0;
    else if (busy) run_cyc <= run_cyc + 1'b1;
  end

  // R4: pulse lasts one cycle
  p_done_single_r4: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R4: pulse arrives WIDTH steps after the accepted start
  p_done_timing_r4: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (run_cyc == KW'(WIDTH)));

  // R5: a start while busy does not restart the run
  p_start_ignored_r5: assert property (@(posedge clk) disable iff (rst)
    (busy && start_i && !done_o) |=> (busy || done_o));

  // R6: result words only move with done
  p_hold_hi_r6: assert property (@(posedge clk) disable iff (rst)
    !done_o |=> ($stable(hi_o) || done_o));

  p_hold_lo_r6: assert property (@(posedge clk) disable iff (rst)
    !done_o |=> ($stable(lo_o) || done_o));
endmodule

bind booth_mul_seq booth_mul_seq_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .busy(busy),
  .done_o(done_o), .hi_o(hi_o), .lo_o(lo_o)
);

// File: tb/booth_mul_seq_test.sv
module booth_mul_seq_test;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start_i = 1'b0;
  logic         signed_i = 1'b0;
  logic [W-1:0] mcand_i = '0;
  logic [W-1:0] mplier_i = '0;
  logic [W-1:0] hi_o, lo_o;
  logic         done_o;

  int vectors = 0;
  int miscompares = 0;
  string tag = "R1";

  // model state
  logic           m_busy = 1'b0;
  int             m_cnt = 0;
  logic           m_done = 1'b0;
  logic [2*W-1:0] m_prod = '0;
  logic [2*W-1:0] m_pend = '0;

  booth_mul_seq #(.WIDTH(W)) uut (
    .clk(clk), .rst(rst), .start_i(start_i), .signed_i(signed_i),
    .mcand_i(mcand_i), .mplier_i(mplier_i),
    .hi_o(hi_o), .lo_o(lo_o), .done_o(done_o)
  );

  always #2.5 clk = ~clk;

  function automatic logic [2*W-1:0] ref_mul(logic [W-1:0] a, logic [W-1:0] b, logic sg);
    logic [2*W-1:0] ax, bx;
    ax = sg ? {{W{a[W-1]}}, a} : {{W{1'b0}}, a};
    bx = sg ? {{W{b[W-1]}}, b} : {{W{1'b0}}, b};
    return ax * bx;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 1'b0; m_cnt = 0; m_done = 1'b0; m_prod = '0;
    end else begin
      m_done = 1'b0;
      if (!m_busy && start_i) begin
        m_busy = 1'b1; m_cnt = 0;
        m_pend = ref_mul(mcand_i, mplier_i, signed_i);
      end else if (m_busy) begin
        if (m_cnt == W - 1) begin
          m_busy = 1'b0; m_done = 1'b1; m_prod = m_pend;
        end
        m_cnt = m_cnt + 1;
      end
    end
  end

  always @(negedge clk) begin
    vectors++;
    if (done_o !== m_done) begin
      miscompares++;
      $display("FAIL %s done_o actual=%0b expected=%0b", tag, done_o, m_done);
    end
    if ({hi_o, lo_o} !== m_prod) begin
      miscompares++;
      $display("FAIL %s product actual=%h_%h expected=%h", tag, hi_o, lo_o, m_prod);
    end
  end

  task automatic pulse(input logic [W-1:0] a, input logic [W-1:0] b, input logic sg);
    @(negedge clk);
    mcand_i = a; mplier_i = b; signed_i = sg; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic run(input logic [W-1:0] a, input logic [W-1:0] b, input logic sg);
    pulse(a, b, sg);
    repeat (W + 2) @(negedge clk);
  endtask

  initial begin
    int wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 100000) begin
        miscompares++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
      end
    end
  end

  initial begin
    tag = "R1";
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    tag = "R2";
    run(32'd2, 32'd7, 1'b1);
    run(32'd2, 32'hFFFF_FFFD, 1'b1);
    run(32'hFFFF_F000, 32'hFFFF_FF85, 1'b1);
    run(32'h1234_5678, 32'h8765_4321, 1'b1);
    run(32'h5555_5555, 32'hAAAA_AAAA, 1'b1);
    run(32'd0, 32'hDEAD_BEEF, 1'b1);

    tag = "R3";
    run(32'd8, 32'd9, 1'b0);
    run(32'h8765_4321, 32'h1234_5678, 1'b0);
    run(32'hF0F0_0001, 32'h8000_0003, 1'b0);

    tag = "R7";
    run(32'h8000_0000, 32'h8000_0000, 1'b1);
    run(32'h8000_0000, 32'hFFFF_FFFF, 1'b1);
    run(32'h7FFF_FFFF, 32'h8000_0000, 1'b1);

    tag = "R8";
    run(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);

    tag = "R4";
    pulse(32'd3, 32'd5, 1'b0);
    pulse(32'd11, 32'd13, 1'b1);
    repeat (W + 2) @(negedge clk);

    tag = "R5";
    pulse(32'h0000_1234, 32'h0000_00FF, 1'b1);
    repeat (7) @(negedge clk);
    pulse(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
    repeat (W) @(negedge clk);

    tag = "R9";
    pulse(32'hFFFF_FFFE, 32'h0000_0003, 1'b1);
    @(negedge clk);
    signed_i = 1'b0; mcand_i = 32'h7; mplier_i = 32'h9;
    repeat (W + 2) @(negedge clk);

    tag = "R6";
    repeat (10) @(negedge clk);
    run(32'hCAFE_0001, 32'h0000_0002, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule